// File: doc/BRIEF.md
# Multi-Channel Audio Interrupt Register Bank

This block collects interrupt events from a multi-channel audio serial port and turns them into one interrupt line. Events fall into two 32-bit words. Word A carries four per-channel groups of eight bits: transmit ready, transmit underrun, receive ready and receive overflow. Word B carries port-wide events: a write error and four FIFO level conditions. Each word has its own mask register. Software sets mask bits through one write-only address and clears them through another. The mask itself is only read, never written.

Ready and FIFO-level bits copy their live input with a one-cycle delay. Underrun, overflow and write-error bits are sticky. A read of the word's status register returns the current value, and the sticky bits clear at the following clock edge. A channel-count input states how many audio channels are in use. Per-channel bits for channels at or above that count read as zero and cannot raise the interrupt.

Top module: `aud_irq_bank`

## Requirements
- R1: After reset every mask bit and every status bit is 0 and `irq` is low.
- R2: A write to address 0 (word A) or 4 (word B) sets each mask bit whose write-data bit is 1. Bits written as 0 are left unchanged. The new mask reads back at address 2 (word A) or 6 (word B) in the cycle after the write.
- R3: A write to address 1 (word A) or 5 (word B) clears each mask bit whose write-data bit is 1. Other mask bits are left unchanged.
- R4: Writes to the mask addresses (2, 6) and the status addresses (3, 7) have no effect on any register.
- R5: Word A status (address 3) places channel c of transmit ready at bit c, transmit underrun at bit 8+c, receive ready at bit 16+c and receive overflow at bit 24+c. The ready bits show the input as sampled at the previous clock edge.
- R6: An underrun or overflow bit set by a one-cycle pulse stays set until word A status is read. A read returns the value from before the clear, and the bit reads 0 after that. An event arriving in the same cycle as the read stays set.
- R7: Word B status (address 7) shows write error at bit 0, transmit FIFO ready at bit 8, transmit FIFO empty at bit 9, receive FIFO ready at bit 12 and receive FIFO full at bit 13. Write error is sticky and clears on a read of address 7. The FIFO bits follow their inputs with one cycle of delay.
- R8: With channel count N, bits c >= N of every per-channel field read 0 in the word A mask and status, and they cannot assert `irq`. A count above 8 acts as 8.
- R9: `irq` is high exactly when some bit is set in both the mask and the status of the same word.
- R10: Word B bits other than 0, 8, 9, 12 and 13 always read 0, including in the mask after an all-ones set write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_count | input | 4 | Number of active audio channels (0 to 8; larger values act as 8) |
| tx_ready | input | 8 | Per-channel transmit ready level |
| tx_underrun | input | 8 | Per-channel transmit underrun event |
| rx_ready | input | 8 | Per-channel receive ready level |
| rx_overflow | input | 8 | Per-channel receive overflow event |
| write_err | input | 1 | Write error event |
| txf_ready | input | 1 | Transmit FIFO ready level |
| txf_empty | input | 1 | Transmit FIFO empty level |
| rxf_ready | input | 1 | Receive FIFO ready level |
| rxf_full | input | 1 | Receive FIFO full level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears its sticky bits) |
| reg_addr | input | 3 | Word address: 0 set A, 1 clear A, 2 mask A, 3 status A, 4 to 7 the same for B |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register; write-only addresses read 0 |
| irq | output | 1 | Interrupt request |

## Verification
If a mask bit is set or cleared wrongly, the fault appears at the ports in the next cycle: a read of the mask returns the wrong value, and `irq` changes state when a matching status bit is set. If a sticky bit is lost or keeps a stale value, the first status read after the event shows it, and a second read exposes a clear that did not happen. If the channel limit is not applied, bits above the count appear in the readback, or `irq` rises when only masked-out channels are active, in the cycle after the event.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int WORD_W       = 32;
  localparam int FIELD_STRIDE = 8;
  localparam int NUM_FIELDS   = 4;
  localparam int NUM_WORDS    = 2;

  // word address map, per word: set, clear, mask, status
  localparam logic [1:0] OFS_SET  = 2'd0;
  localparam logic [1:0] OFS_CLR  = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  // word A: odd fields (underrun, overflow) are sticky
  localparam logic [WORD_W-1:0] STICKY_A = 32'hFF00_FF00;
  localparam logic [WORD_W-1:0] IMPL_A   = 32'hFFFF_FFFF;
  // word B: bit0 write error (sticky), 8/9 tx fifo, 12/13 rx fifo
  localparam int B_WERR  = 0;
  localparam int B_TXRDY = 8;
  localparam int B_TXEMP = 9;
  localparam int B_RXRDY = 12;
  localparam int B_RXFUL = 13;
  localparam logic [WORD_W-1:0] STICKY_B = 32'h0000_0001;
  localparam logic [WORD_W-1:0] IMPL_B   = 32'h0000_3301;

  // valid bits of word A for a given channel count
  function automatic logic [WORD_W-1:0] chan_word_valid(int nch, int cnt);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int f = 0; f < NUM_FIELDS; f++)
      for (int c = 0; c < nch; c++)
        v[f*FIELD_STRIDE+c] = (c < cnt);
    return v;
  endfunction
endpackage

// File: rtl/irq_mask_word.sv
module irq_mask_word #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q | (set_i & IMPL)) & ~clr_i;
  end

  assign mask_o = mask_q;

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i != '0) && (clr_i == '0)) |=>
      ((mask_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((mask_q & $past(clr_i)) == '0));

  assert_mask_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(mask_q));
endmodule

// File: rtl/irq_flag_word.sv
module irq_flag_word #(
  parameter int W = 32,
  parameter logic [W-1:0] STICKY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] kept_w;

  assign kept_w = clr_i ? '0 : stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (src_i & ~STICKY) | (STICKY & (kept_w | src_i));
  end

  assign stat_o = stat_q;

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_q & $past(stat_q & STICKY)) == $past(stat_q & STICKY)));

  assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~STICKY) == $past(src_i & ~STICKY)));
endmodule

// File: rtl/aud_irq_bank.sv
module aud_irq_bank
  import aud_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  ch_count,
  input  logic [NUM_CH-1:0] tx_ready,
  input  logic [NUM_CH-1:0] tx_underrun,
  input  logic [NUM_CH-1:0] rx_ready,
  input  logic [NUM_CH-1:0] rx_overflow,
  input  logic              write_err,
  input  logic              txf_ready,
  input  logic              txf_empty,
  input  logic              rxf_ready,
  input  logic              rxf_full,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] src_w, set_w, clr_w, mask_w, stat_w, valid_w, pend_w;
  logic [NUM_WORDS-1:0]             rdclr_w;
  logic [NUM_CH-1:0][NUM_FIELDS-1:0] unused_chk;
  logic [NUM_FIELDS-1:0][NUM_CH-1:0] field_in;
  logic [WORD_W-1:0]                 chan_valid;

  assign unused_chk = '0;
  assign chan_valid = chan_word_valid(NUM_CH, int'(ch_count));
  assign field_in   = {rx_overflow, rx_ready, tx_underrun, tx_ready};

  // word A source: per-channel fields at a fixed stride
  always_comb begin
    src_w[0] = '0;
    for (int f = 0; f < NUM_FIELDS; f++)
      src_w[0][f*FIELD_STRIDE +: NUM_CH] = field_in[f];
    src_w[0] = src_w[0] & chan_valid;
    src_w[1] = '0;
    src_w[1][B_WERR]  = write_err;
    src_w[1][B_TXRDY] = txf_ready;
    src_w[1][B_TXEMP] = txf_empty;
    src_w[1][B_RXRDY] = rxf_ready;
    src_w[1][B_RXFUL] = rxf_full;
  end

  assign valid_w[0] = chan_valid;
  assign valid_w[1] = IMPL_B;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic sel_w;
    assign sel_w      = (reg_addr[2] == 1'(w));
    assign set_w[w]   = (reg_wr && sel_w && reg_addr[1:0] == OFS_SET) ? reg_wdata : '0;
    assign clr_w[w]   = (reg_wr && sel_w && reg_addr[1:0] == OFS_CLR) ? reg_wdata : '0;
    assign rdclr_w[w] = reg_rd && sel_w && (reg_addr[1:0] == OFS_STAT);
    assign pend_w[w]  = mask_w[w] & stat_w[w] & valid_w[w];

    irq_mask_word #(.W(WORD_W), .IMPL(w == 0 ? IMPL_A : IMPL_B)) u_mask (
      .clk(clk), .rst_n(rst_n), .set_i(set_w[w]), .clr_i(clr_w[w]), .mask_o(mask_w[w]));

    irq_flag_word #(.W(WORD_W), .STICKY(w == 0 ? STICKY_A : STICKY_B)) u_flag (
      .clk(clk), .rst_n(rst_n), .src_i(src_w[w]), .clr_i(rdclr_w[w]), .stat_o(stat_w[w]));
  end

  always_comb begin
    unique case (reg_addr[1:0])
      OFS_MASK: reg_rdata = mask_w[reg_addr[2]] & valid_w[reg_addr[2]];
      OFS_STAT: reg_rdata = stat_w[reg_addr[2]] & valid_w[reg_addr[2]];
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = |pend_w;

  assert_b_unimpl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_w[1] | stat_w[1]) & ~IMPL_B) == '0);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((mask_w[0] & stat_w[0]) != '0 || (mask_w[1] & stat_w[1]) != '0));
endmodule

// File: tb/aud_irq_bank_tb.sv
module aud_irq_bank_tb;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  ch_count = 4'd8;
  logic [7:0]  tx_ready = 0, tx_underrun = 0, rx_ready = 0, rx_overflow = 0;
  logic        write_err = 0, txf_ready = 0, txf_empty = 0, rxf_ready = 0, rxf_full = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  aud_irq_bank u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rdchk(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    rdchk("R1", 3'd2, 0); rdchk("R1", 3'd3, 0);
    rdchk("R1", 3'd6, 0); rdchk("R1", 3'd7, 0);
    chk("R1", {31'b0, irq}, 0);
  endtask

  task automatic t_mask();
    wr(3'd0, 32'h0000_0105); rdchk("R2", 3'd2, 32'h0000_0105);
    wr(3'd0, 32'h0001_0000); rdchk("R2", 3'd2, 32'h0001_0105);
    wr(3'd1, 32'h0000_0100); rdchk("R3", 3'd2, 32'h0001_0005);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
    rdchk("R4", 3'd2, 32'h0001_0005); rdchk("R4", 3'd3, 0);
  endtask

  task automatic t_level();
    @(negedge clk); tx_ready = 8'h0A; rx_ready = 8'h30;
    rdchk("R5", 3'd3, 32'h0030_000A);
    chk("R9", {31'b0, irq}, 0);
    @(negedge clk); tx_ready = 8'h01; rx_ready = 0;
    @(negedge clk); chk("R9", {31'b0, irq}, 1);
    rdchk("R5", 3'd3, 32'h0000_0001);
    tx_ready = 0;
    @(negedge clk); chk("R9", {31'b0, irq}, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    @(negedge clk); tx_underrun = 8'h04;
    @(negedge clk); tx_underrun = 0;
    @(negedge clk);
    rdchk("R6", 3'd3, 32'h0000_0400);
    rdchk("R6", 3'd3, 32'h0000_0000);
    @(negedge clk); reg_rd = 1; reg_addr = 3'd3; rx_overflow = 8'h01; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; rx_overflow = 0;
    chk("R6", d, 0);
    rdchk("R6", 3'd3, 32'h0100_0000);
    rdchk("R6", 3'd3, 0);
  endtask

  task automatic t_wordb();
    @(negedge clk); write_err = 1; txf_empty = 1;
    @(negedge clk); write_err = 0;
    rdchk("R7", 3'd7, 32'h0000_0201);
    rdchk("R7", 3'd7, 32'h0000_0200);
    wr(3'd4, 32'hFFFF_FFFF);
    rdchk("R10", 3'd6, 32'h0000_3301);
    @(negedge clk); chk("R9", {31'b0, irq}, 1);
    txf_empty = 0; rxf_full = 1; rxf_ready = 1; txf_ready = 1;
    rdchk("R7", 3'd7, 32'h0000_3100);
    rxf_full = 0; rxf_ready = 0; txf_ready = 0;
    wr(3'd5, 32'hFFFF_FFFF);
    rdchk("R3", 3'd6, 0);
    @(negedge clk); chk("R9", {31'b0, irq}, 0);
  endtask

  task automatic t_chan();
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk); ch_count = 4'd4;
    wr(3'd0, 32'hFFFF_FFFF);
    rdchk("R8", 3'd2, 32'h0F0F_0F0F);
    @(negedge clk); tx_ready = 8'hFF;
    rdchk("R8", 3'd3, 32'h0000_000F);
    @(negedge clk); tx_ready = 8'hF0;
    @(negedge clk); @(negedge clk);
    chk("R8", {31'b0, irq}, 0);
    ch_count = 4'd12;
    rdchk("R8", 3'd2, 32'hFFFF_FFFF);
    @(negedge clk); chk("R8", {31'b0, irq}, 1);
    ch_count = 4'd0; tx_ready = 8'hFF;
    @(negedge clk); @(negedge clk);
    chk("R8", {31'b0, irq}, 0);
    rdchk("R8", 3'd3, 0);
    tx_ready = 0;
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mask();
    t_level();
    t_sticky();
    t_wordb();
    t_chan();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule